// File: doc/BRIEF.md
# Four-Stage Shift/Load Register with Serial Output

This block is a short register chain that, on each rising clock edge, either captures a parallel word or moves its contents one stage toward the high end. A single mode input selects between the two behaviours. The last stage drives a serial output, so the block can turn a parallel word into a bit stream, highest stage first.

The lowest stage behaves differently from the others. It always captures parallel bit 0, in both modes. As a result, during a run of shift clocks, parallel bit 0 keeps entering at the low end while the older bits move toward the serial output. An active-low clear input forces every stage to zero at once, without waiting for a clock edge. The clear also holds the chain at zero for as long as it stays low.

A typical sequence is: clear the block, apply one load clock, then apply shift clocks and read one bit per clock from the serial output.

Top module: `shift_load_reg`

## Requirements
- R1: While `clr_n` is 0, every bit of `stage_q` reads 0. The clear takes effect immediately, with no clock edge needed.
- R2: On every rising edge with `clr_n` high, stage 0 (`stage_q[0]`) takes `par_in[0]`. This holds whatever the value of `shift_en`.
- R3: On a rising edge with `clr_n` high and `shift_en` = 1, each stage i from 1 to 3 takes the value stage i-1 held before the edge.
- R4: On a rising edge with `clr_n` high and `shift_en` = 0, each stage i from 1 to 3 takes `par_in[i]`.
- R5: `ser_out` always equals `stage_q[3]`.
- R6: After a clear, a load clock with `par_in` = 4'b1010 (bit 3 = 1, bit 2 = 0, bit 1 = 1, bit 0 = 0) is followed by three shift clocks. Across the load and the shifts, `ser_out` reads 1, 0, 1, 0, one value per clock.
- R7: Rising clock edges that occur while `clr_n` is 0 leave every stage at 0, whatever `shift_en` and `par_in` are.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the register updates on its rising edge |
| clr_n | input | 1 | Asynchronous clear, active low |
| shift_en | input | 1 | Mode select: 1 = shift toward the high end, 0 = parallel load |
| par_in | input | 4 | Parallel data; bit i feeds stage i |
| stage_q | output | 4 | Current value of every stage; bit i is stage i |
| ser_out | output | 1 | Serial output, taken from stage 3 |

## Verification
Two functions act in the same cycle on every shift edge. Stage 0 reloads `par_in[0]` while stages 1 to 3 move their contents up one place. The bench provokes this by loading each of the 16 possible starting words and then applying one shift or load edge with every one of the 16 parallel words. It judges each edge against a result computed arithmetically: the old word shifted left, masked to the upper three bits, with `par_in[0]` inserted at bit 0. A second overlap is clear against clock. The bench asserts clear between edges and keeps it low across edges that carry nonzero data, and it expects the chain to stay at zero in both cases.

// File: rtl/shl_pkg.sv
// Package: shared types and constants for the shift/load register.
// Assumes: a single-bit mode select, where 1 means shift and 0 means load.
package shl_pkg;
    localparam int unsigned SHL_STAGES = 4;

    typedef enum logic {
        SHL_LOAD  = 1'b0,
        SHL_SHIFT = 1'b1
    } shl_mode_e;
endpackage

// File: rtl/shl_stage.sv
// Module: one register stage. On each rising edge it captures either the
// value of the stage below it or its own parallel bit, depending on the mode.
// Assumes: clr_n is an asynchronous, active-low clear to 0.
module shl_stage
    import shl_pkg::*;
(
    input  logic      clk,
    input  logic      clr_n,
    input  shl_mode_e mode,
    input  logic      prev_q,
    input  logic      par_d,
    output logic      q
);
    logic next_q;

    // Purpose: choose the value this stage captures at the next edge.
    always_comb begin
        if (mode == SHL_SHIFT) begin
            next_q = prev_q;
        end else begin
            next_q = par_d;
        end
    end

    // Purpose: the stage flop, with an asynchronous clear to 0.
    always_ff @(posedge clk or negedge clr_n) begin
        if (!clr_n) begin
            q <= 1'b0;
        end else begin
            q <= next_q;
        end
    end
endmodule

// File: rtl/shl_chain.sv
// Module: a chain of stages. Stage 0 takes par_in[0] as its "previous"
// value, so it captures parallel bit 0 in both modes. Each stage above it
// takes its neighbour below as the shift source.
// Assumes: STAGES is 2 or more.
module shl_chain
    import shl_pkg::*;
#(
    parameter int unsigned STAGES = SHL_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  shl_mode_e         mode,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] stage_q
);
    localparam int unsigned TOP = STAGES - 1;

    logic [STAGES-1:0] shift_src;

    // Purpose: give the low stage its parallel bit, and each higher stage its lower neighbour.
    assign shift_src = {stage_q[TOP-1:0], par_in[0]};

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        shl_stage u_stage (
            .clk    (clk),
            .clr_n  (clr_n),
            .mode   (mode),
            .prev_q (shift_src[g]),
            .par_d  (par_in[g]),
            .q      (stage_q[g])
        );
    end

    // R2
    head_load_chk: assert property (@(posedge clk) disable iff (!clr_n)
        1'b1 |=> stage_q[0] == $past(par_in[0]));

    // R3
    shift_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode == SHL_SHIFT |=> stage_q[TOP:1] == $past(stage_q[TOP-1:0]));

    // R4
    load_step_chk: assert property (@(posedge clk) disable iff (!clr_n)
        mode == SHL_LOAD |=> stage_q[TOP:1] == $past(par_in[TOP:1]));
endmodule

// File: rtl/shift_load_reg.sv
// Module: top level of the shift/load register. It turns the plain mode bit
// into the shared mode type and takes the serial output from the last stage.
// Assumes: shift_en is stable around the rising clock edge.
module shift_load_reg
    import shl_pkg::*;
#(
    parameter int unsigned STAGES = SHL_STAGES
) (
    input  logic              clk,
    input  logic              clr_n,
    input  logic              shift_en,
    input  logic [STAGES-1:0] par_in,
    output logic [STAGES-1:0] stage_q,
    output logic              ser_out
);
    shl_mode_e mode;

    // Purpose: map the mode pin onto the shared mode type.
    assign mode = shift_en ? SHL_SHIFT : SHL_LOAD;

    shl_chain #(.STAGES(STAGES)) u_chain (
        .clk     (clk),
        .clr_n   (clr_n),
        .mode    (mode),
        .par_in  (par_in),
        .stage_q (stage_q)
    );

    // Purpose: serial output from the highest stage.
    assign ser_out = stage_q[STAGES-1];

    // R1 R7
    clear_zero_chk: assert property (@(posedge clk)
        !clr_n |-> stage_q == '0);
endmodule

// File: tb/test_shift_load_reg.sv
module test_shift_load_reg;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       clr_n;
    logic       shift_en;
    logic [3:0] par_in;
    logic [3:0] stage_q;
    logic       ser_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    shift_load_reg i_shift_load_reg (
        .clk      (clk),
        .clr_n    (clr_n),
        .shift_en (shift_en),
        .par_in   (par_in),
        .stage_q  (stage_q),
        .ser_out  (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %b expected %b", req, act, exp);
        end
    endtask

    // Drive the inputs at the falling edge, then sample 1 unit after the next rising edge.
    task automatic apply(input logic sh, input logic [3:0] d);
        @(negedge clk);
        shift_en = sh;
        par_in   = d;
        @(posedge clk);
        #1;
    endtask

    initial begin
        clr_n = 1'b0;
        shift_en = 1'b0;
        par_in = 4'h0;
        repeat (2) @(posedge clk);
        #1;
        check("R1 reset state", stage_q, 4'h0);
        @(negedge clk);
        clr_n = 1'b1;

        // Sweep: every starting word, every parallel word, both modes.
        for (int s = 0; s < 16; s++) begin
            for (int d = 0; d < 16; d++) begin
                for (int m = 0; m < 2; m++) begin
                    logic [3:0] exp;
                    apply(1'b0, 4'(s));
                    check("R4 load word", stage_q, 4'(s));
                    apply(m[0], 4'(d));
                    if (m == 1) begin
                        exp = 4'(((s << 1) & 4'hE) | (d & 1));
                        check("R3 R2 shift with head reload", stage_q, exp);
                    end else begin
                        exp = 4'(d);
                        check("R4 R2 load", stage_q, exp);
                    end
                    check("R5 serial tap", {3'b0, ser_out}, {3'b0, exp[3]});
                end
            end
        end

        // R1: asynchronous clear between edges.
        apply(1'b0, 4'hF);
        check("R4 preload", stage_q, 4'hF);
        @(negedge clk);
        #2;
        clr_n = 1'b0;
        #1;
        check("R1 async clear without edge", stage_q, 4'h0);
        // R7: edges during clear have no effect.
        shift_en = 1'b0;
        par_in = 4'hF;
        @(posedge clk);
        #1;
        check("R7 load edge during clear", stage_q, 4'h0);
        shift_en = 1'b1;
        @(posedge clk);
        #1;
        check("R7 shift edge during clear", stage_q, 4'h0);
        @(negedge clk);
        clr_n = 1'b1;

        // R6: load 1010 after clear, then shift it out of the serial output.
        apply(1'b0, 4'b1010);
        check("R6 serial bit 0", {3'b0, ser_out}, 4'h1);
        apply(1'b1, 4'b1010);
        check("R6 serial bit 1", {3'b0, ser_out}, 4'h0);
        apply(1'b1, 4'b1010);
        check("R6 serial bit 2", {3'b0, ser_out}, 4'h1);
        apply(1'b1, 4'b1010);
        check("R6 serial bit 3", {3'b0, ser_out}, 4'h0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule